// File: doc/BRIEF.md
# Host-Loadable Microprogram Sequencer

This block is the control unit of a microcoded coprocessor. A single mode input splits its life into two phases. While the mode input is low, a host owns the block: it loads microinstructions into a 256-word, 32-bit control store and reads or writes a 16-entry, 32-bit register file, all through a 9-bit address and a 32-bit data path. While the mode input is high, the host is locked out and the sequencer fetches and executes one microinstruction per clock, starting at address 0.

A microinstruction holds an 8-bit opcode in bits [31:24], a destination register in [23:20], source A in [19:16], source B in [15:12] and a 12-bit immediate in [11:0]. Branch targets are the low 8 bits of the immediate. Program control offers an unconditional jump, a jump taken when source A is zero, a subroutine call, a return and a halt. Calls nest at most two deep. A small set of data instructions (XOR, AND, rotate left, move, load immediate) exercises the register file. A halt raises a done flag. A stack overflow or underflow also raises a sticky error flag and stops execution. Both flags hold until the mode input returns low.

The controller has four states. HOST is entered after reset and whenever the mode input is low. HOST goes to RUN on the first clock with the mode input high. RUN loops on itself per instruction, goes to DONE on a halt and goes to FAULT on a stack error. DONE and FAULT hold until the mode input is low, which returns every state to HOST.

Top module: `useq_ctrl`

## Requirements
- R1: With the mode input low, a host write to addresses 0x000–0x0FF stores a word in the control store. A host read of those addresses returns the stored word in the same cycle.
- R2: With the mode input low, addresses 0x100–0x10F map to registers D0–D15 for reads and writes. A read of any other address at or above 0x110 returns zero, and a write to such an address changes nothing.
- R3: While the mode input is high, the read data output is zero and host writes are ignored, so register contents (keys) stay hidden and unchanged.
- R4: When the mode input rises, the program counter starts at 0. After one idle clock, one instruction executes per clock. A program of one load followed by a halt raises done on the third clock edge after the rise.
- R5: Data opcodes have these encodings and results: 0x01 XOR (D = A ^ B); 0x02 AND (D = A & B); 0x03 rotate left (D = A rotated left by imm[4:0]); 0x04 MOV (D = A); 0x05 load immediate (D = zero-extended imm[11:0]). The result is written at the end of the same clock, so the next instruction can read it.
- R6: Opcode 0x10 jumps to imm[7:0]. Opcode 0x11 jumps to imm[7:0] when source A is zero and otherwise falls through.
- R7: Opcode 0x12 calls imm[7:0] and saves the next address. Opcode 0x13 returns to the most recently saved address. Two nested levels are supported.
- R8: A call made while two levels are already saved, or a return with nothing saved, sets both error and done and stops execution.
- R9: Opcode 0x1F halts and sets done. Done and error hold while the mode input stays high. Both are cleared on the first clock after the mode input is low.
- R10: Opcodes with no assigned meaning act as no-operation and write no register.
- R11: After reset, done, error and the read data output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | Low: host access; high: microcode execution |
| host_addr | input | 9 | Host address: control store or register file |
| host_wdata | input | 32 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read data, zero unless reading in host mode |
| done | output | 1 | Execution stopped by halt or error |
| err | output | 1 | Sticky return-stack error |

## Verification
Two functions can fall in the same clock: a host write and microcode execution. The bench provokes this by issuing a host write to a register in the middle of a running loop. It judges the outcome by dropping the mode input afterwards and reading the register back at its old value. Two other pairs are driven directly. One is a return that restores a saved address while the next call already pushes. The other is a halt whose done flag must persist while the host read path stays blank.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int DATA_W   = 32;
    localparam int UDEPTH   = 256;
    localparam int NREGS    = 16;
    localparam int HADDR_W  = 9;
    localparam int STK_DEP  = 2;
    localparam int UPC_W    = $clog2(UDEPTH);
    localparam int RIDX_W   = $clog2(NREGS);
    localparam int IMM_W    = 12;

    typedef enum logic [7:0] {
        OP_NOP  = 8'h00,
        OP_XOR  = 8'h01,
        OP_AND  = 8'h02,
        OP_ROL  = 8'h03,
        OP_MOV  = 8'h04,
        OP_LDI  = 8'h05,
        OP_JMP  = 8'h10,
        OP_JZ   = 8'h11,
        OP_CALL = 8'h12,
        OP_RET  = 8'h13,
        OP_HALT = 8'h1F
    } opcode_e;

    typedef enum logic [1:0] {
        ST_HOST  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/useq_ustore.sv
module useq_ustore #(
    parameter int DEPTH = 256,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] fetch_addr,
    output logic [W-1:0]             fetch_data,
    input  logic [$clog2(DEPTH)-1:0] peek_addr,
    output logic [W-1:0]             peek_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign fetch_data = mem[fetch_addr];
    assign peek_data  = mem[peek_addr];
endmodule

// File: rtl/useq_regfile.sv
module useq_regfile #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ra,
    output logic [W-1:0]         rdata_a,
    input  logic [$clog2(N)-1:0] rb,
    output logic [W-1:0]         rdata_b,
    input  logic [$clog2(N)-1:0] rh,
    output logic [W-1:0]         rdata_h
);
    logic [W-1:0] regs [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (we && (waddr == ($clog2(N))'(i))) begin
                    regs[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata_a = regs[ra];
    assign rdata_b = regs[rb];
    assign rdata_h = regs[rh];
endmodule

// File: rtl/useq_retstack.sv
module useq_retstack #(
    parameter int DEPTH = 2,
    parameter int AW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       pop,
    input  logic [AW-1:0]              push_addr,
    output logic [AW-1:0]              top_addr,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] slot [DEPTH];
    logic [LW-1:0] lvl_q;
    logic [IW-1:0] top_idx;

    assign full    = (lvl_q == LW'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign level   = lvl_q;
    assign top_idx = IW'(lvl_q - LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (clear) begin
            lvl_q <= '0;
        end else if (push && !full) begin
            lvl_q <= lvl_q + LW'(1);
        end else if (pop && !empty) begin
            lvl_q <= lvl_q - LW'(1);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!clear && push && !full && (lvl_q == LW'(i))) begin
                    slot[i] <= push_addr;
                end
            end
        end
    endgenerate

    assign top_addr = empty ? '0 : slot[top_idx];
endmodule

// File: rtl/useq_alu.sv
module useq_alu
    import useq_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 12
) (
    input  logic [7:0]    op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  result,
    output logic          wr
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] sh;
    logic [2*W-1:0]  dbl;

    assign sh  = imm[SH_W-1:0];
    assign dbl = {a, a} << sh;

    always_comb begin
        result = '0;
        wr     = 1'b0;
        case (op)
            OP_XOR: begin result = a ^ b;            wr = 1'b1; end
            OP_AND: begin result = a & b;            wr = 1'b1; end
            OP_ROL: begin result = dbl[2*W-1:W];     wr = 1'b1; end
            OP_MOV: begin result = a;                wr = 1'b1; end
            OP_LDI: begin result = W'(imm);          wr = 1'b1; end
            default: begin result = '0;              wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_mode,
    input  logic [HADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic                 host_wr,
    input  logic                 host_rd,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 done,
    output logic                 err
);
    localparam int LVL_W = $clog2(STK_DEP + 1);

    seq_state_e st_q, st_d;
    logic [UPC_W-1:0]  pc_q, pc_nxt;
    logic [DATA_W-1:0] instr, peek_word;
    logic [7:0]        op;
    logic [RIDX_W-1:0] f_dst, f_sa, f_sb;
    logic [IMM_W-1:0]  f_imm;
    logic [UPC_W-1:0]  f_tgt;
    logic [DATA_W-1:0] va, vb, vh, alu_res;
    logic              alu_wr;
    logic              exec, do_halt, do_fault, do_push, do_pop;
    logic [UPC_W-1:0]  stk_top;
    logic              stk_full, stk_empty;
    logic [LVL_W-1:0]  stk_level;
    logic              host_on, host_reg_sel, host_mem_sel;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    // instruction fields
    assign op    = instr[31:24];
    assign f_dst = instr[23:20];
    assign f_sa  = instr[19:16];
    assign f_sb  = instr[15:12];
    assign f_imm = instr[IMM_W-1:0];
    assign f_tgt = f_imm[UPC_W-1:0];

    // host decode
    assign host_on      = !run_mode;
    assign host_mem_sel = (host_addr[HADDR_W-1] == 1'b0);
    assign host_reg_sel = host_addr[HADDR_W-1] &&
                          (host_addr[HADDR_W-2:RIDX_W] == '0);

    useq_ustore #(.DEPTH(UDEPTH), .W(DATA_W)) u_store (
        .clk        (clk),
        .we         (host_on && host_wr && host_mem_sel),
        .waddr      (host_addr[UPC_W-1:0]),
        .wdata      (host_wdata),
        .fetch_addr (pc_q),
        .fetch_data (instr),
        .peek_addr  (host_addr[UPC_W-1:0]),
        .peek_data  (peek_word)
    );

    useq_regfile #(.N(NREGS), .W(DATA_W)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra      (f_sa),
        .rdata_a (va),
        .rb      (f_sb),
        .rdata_b (vb),
        .rh      (host_addr[RIDX_W-1:0]),
        .rdata_h (vh)
    );

    useq_alu #(.W(DATA_W), .IW(IMM_W)) u_alu (
        .op     (op),
        .a      (va),
        .b      (vb),
        .imm    (f_imm),
        .result (alu_res),
        .wr     (alu_wr)
    );

    useq_retstack #(.DEPTH(STK_DEP), .AW(UPC_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st_q == ST_HOST),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (pc_q + UPC_W'(1)),
        .top_addr  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .level     (stk_level)
    );

    // register file write mux: host and microcode never overlap
    always_comb begin
        if (host_on) begin
            rf_we    = host_wr && host_reg_sel;
            rf_waddr = host_addr[RIDX_W-1:0];
            rf_wdata = host_wdata;
        end else begin
            rf_we    = exec && alu_wr;
            rf_waddr = f_dst;
            rf_wdata = alu_res;
        end
    end

    // program control decode
    always_comb begin
        pc_nxt   = pc_q + UPC_W'(1);
        do_halt  = 1'b0;
        do_fault = 1'b0;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        if (exec) begin
            case (op)
                OP_JMP:  pc_nxt = f_tgt;
                OP_JZ:   if (va == '0) pc_nxt = f_tgt;
                OP_CALL: begin
                    if (stk_full) begin
                        do_fault = 1'b1;
                    end else begin
                        do_push = 1'b1;
                        pc_nxt  = f_tgt;
                    end
                end
                OP_RET: begin
                    if (stk_empty) begin
                        do_fault = 1'b1;
                    end else begin
                        do_pop = 1'b1;
                        pc_nxt = stk_top;
                    end
                end
                OP_HALT: do_halt = 1'b1;
                default: pc_nxt = pc_q + UPC_W'(1);
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HOST;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!run_mode) begin
            st_d = ST_HOST;
        end else begin
            unique case (st_q)
                ST_HOST:  st_d = ST_RUN;
                ST_RUN: begin
                    if (do_fault)     st_d = ST_FAULT;
                    else if (do_halt) st_d = ST_DONE;
                    else              st_d = ST_RUN;
                end
                ST_DONE:  st_d = ST_DONE;
                ST_FAULT: st_d = ST_FAULT;
            endcase
        end
    end

    // state outputs
    always_comb begin
        exec = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        unique case (st_q)
            ST_HOST:  ;
            ST_RUN:   exec = run_mode;
            ST_DONE:  done = 1'b1;
            ST_FAULT: begin done = 1'b1; err = 1'b1; end
        endcase
    end

    // program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (st_q == ST_HOST) begin
            pc_q <= '0;
        end else if (exec && !do_halt && !do_fault) begin
            pc_q <= pc_nxt;
        end
    end

    // host read path
    always_comb begin
        host_rdata = '0;
        if (host_on && host_rd) begin
            if (host_mem_sel)      host_rdata = peek_word;
            else if (host_reg_sel) host_rdata = vh;
        end
    end
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int PC_W  = 8,
    parameter int LVL_W = 2,
    parameter int D_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_mode,
    input logic [D_W-1:0]   host_rdata,
    input logic             done,
    input logic             err,
    input logic [PC_W-1:0]  pc,
    input logic [LVL_W-1:0] level
);
    AST_RDATA_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |-> host_rdata == '0); // R3
    AST_PC_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_mode) |=> pc == '0); // R4
    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(2)); // R7
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && run_mode) |=> err); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_mode) |=> done); // R9
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_mode) |=> $stable(pc)); // R9
    AST_HOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |=> (!done && !err)); // R9
endmodule

bind useq_ctrl useq_chk #(
    .PC_W  (useq_pkg::UPC_W),
    .LVL_W ($clog2(useq_pkg::STK_DEP + 1)),
    .D_W   (useq_pkg::DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_mode   (run_mode),
    .host_rdata (host_rdata),
    .done       (done),
    .err        (err),
    .pc         (pc_q),
    .level      (stk_level)
);

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_mode = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        done, err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    useq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .done(done), .err(err)
    );

    // vector: op, a, b, imm, expected D3
    localparam logic [111:0] VEC [7] = '{
        {8'h01, 32'hF0F0_0000, 32'h0FF0_1234, 8'h00, 32'hFF00_1234},
        {8'h02, 32'hFFFF_0000, 32'h1234_5678, 8'h00, 32'h1234_0000},
        {8'h03, 32'h8000_0001, 32'h0000_0000, 8'h04, 32'h0000_0018},
        {8'h03, 32'h1234_5678, 32'h0000_0000, 8'h08, 32'h3456_7812},
        {8'h03, 32'hCAFE_F00D, 32'h0000_0000, 8'h00, 32'hCAFE_F00D},
        {8'h04, 32'hDEAD_BEEF, 32'h1111_1111, 8'h00, 32'hDEAD_BEEF},
        {8'h05, 32'h5555_5555, 32'h0000_0000, 8'hA5, 32'h0000_00A5}
    };

    function automatic logic [31:0] enc(input logic [7:0] op, input logic [3:0] d,
                                        input logic [3:0] a, input logic [3:0] b,
                                        input logic [11:0] imm);
        return {op, d, a, b, imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #(CLK_P/4);
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic run_prog();
        @(negedge clk);
        run_mode = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_mode = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(done == 1'b0 && err == 1'b0 && host_rdata == '0, "R11 reset",
              {30'd0, done, err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 vector table
        for (int v = 0; v < 7; v++) begin
            hwrite(9'h101, VEC[v][103:72]);
            hwrite(9'h102, VEC[v][71:40]);
            hwrite(9'h000, enc(VEC[v][111:104], 4'd3, 4'd1, 4'd2, {4'h0, VEC[v][39:32]}));
            hwrite(9'h001, enc(8'h1F, 0, 0, 0, 0));
            run_prog();
            stop_run();
            hread(9'h103, rv);
            check(rv == VEC[v][31:0], "R5 data op", rv, VEC[v][31:0]);
        end

        // R1: control store round trip
        hwrite(9'h037, 32'h89AB_CDEF);
        hread(9'h037, rv);
        check(rv == 32'h89AB_CDEF, "R1 store readback", rv, 32'h89AB_CDEF);

        // R2: register window and unmapped addresses
        hwrite(9'h10F, 32'h0BAD_F00D);
        hread(9'h10F, rv);
        check(rv == 32'h0BAD_F00D, "R2 reg D15", rv, 32'h0BAD_F00D);
        hwrite(9'h110, 32'hFFFF_FFFF);
        hread(9'h110, rv);
        check(rv == 32'h0, "R2 unmapped read", rv, 32'h0);
        hread(9'h100, rv);
        check(rv != 32'hFFFF_FFFF, "R2 unmapped write", rv, 32'h0);

        // R4: exact start timing and restart from address 0
        hwrite(9'h000, enc(8'h05, 4'd11, 0, 0, 12'h05A));
        hwrite(9'h001, enc(8'h1F, 0, 0, 0, 0));
        @(negedge clk);
        run_mode = 1'b1;
        @(negedge clk); @(negedge clk);
        check(done == 1'b0, "R4 done not early", {31'd0, done}, 32'h0);
        @(negedge clk);
        check(done == 1'b1, "R4 done third edge", {31'd0, done}, 32'h1);
        // R9: done holds while mode high, read path blank (R3)
        repeat (5) @(negedge clk);
        check(done == 1'b1 && err == 1'b0, "R9 done sticky", {30'd0, done, err}, 32'h2);
        host_addr = 9'h10F; host_rd = 1'b1;
        #(CLK_P/4);
        check(host_rdata == '0, "R3 hidden while done", host_rdata, 32'h0);
        host_rd = 1'b0;
        @(negedge clk);
        run_mode = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R9 cleared by host mode", {31'd0, done}, 32'h0);
        hread(9'h10B, rv);
        check(rv == 32'h5A, "R4 first instr", rv, 32'h5A);

        // R3: host write during a running loop is ignored
        hwrite(9'h105, 32'h1357_9BDF);
        hwrite(9'h000, enc(8'h10, 0, 0, 0, 12'h000));
        @(negedge clk);
        run_mode = 1'b1;
        repeat (4) @(negedge clk);
        host_addr = 9'h105; host_wdata = 32'h0; host_wr = 1'b1; host_rd = 1'b1;
        #(CLK_P/4);
        check(host_rdata == '0, "R3 read blank in run", host_rdata, 32'h0);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check(done == 1'b0, "R6 jump loop keeps running", {31'd0, done}, 32'h0);
        stop_run();
        hread(9'h105, rv);
        check(rv == 32'h1357_9BDF, "R3 write ignored", rv, 32'h1357_9BDF);

        // R6: conditional jump, taken and not taken
        for (int t = 0; t < 2; t++) begin
            hwrite(9'h101, (t == 0) ? 32'h0 : 32'h8);
            hwrite(9'h000, enc(8'h11, 0, 4'd1, 0, 12'h003));
            hwrite(9'h001, enc(8'h05, 4'd4, 0, 0, 12'h001));
            hwrite(9'h002, enc(8'h1F, 0, 0, 0, 0));
            hwrite(9'h003, enc(8'h05, 4'd4, 0, 0, 12'h002));
            hwrite(9'h004, enc(8'h1F, 0, 0, 0, 0));
            run_prog();
            stop_run();
            hread(9'h104, rv);
            check(rv == ((t == 0) ? 32'h2 : 32'h1), "R6 jz", rv, (t == 0) ? 32'h2 : 32'h1);
        end

        // R7: two nested calls and returns
        hwrite(9'h000, enc(8'h12, 0, 0, 0, 12'h00A));
        hwrite(9'h001, enc(8'h05, 4'd6, 0, 0, 12'h033));
        hwrite(9'h002, enc(8'h1F, 0, 0, 0, 0));
        hwrite(9'h00A, enc(8'h12, 0, 0, 0, 12'h014));
        hwrite(9'h00B, enc(8'h05, 4'd5, 0, 0, 12'h022));
        hwrite(9'h00C, enc(8'h13, 0, 0, 0, 0));
        hwrite(9'h014, enc(8'h05, 4'd7, 0, 0, 12'h011));
        hwrite(9'h015, enc(8'h13, 0, 0, 0, 0));
        run_prog();
        check(err == 1'b0 && done == 1'b1, "R7 no error", {30'd0, done, err}, 32'h2);
        stop_run();
        hread(9'h105, rv); check(rv == 32'h22, "R7 level1 return", rv, 32'h22);
        hread(9'h106, rv); check(rv == 32'h33, "R7 level0 return", rv, 32'h33);
        hread(9'h107, rv); check(rv == 32'h11, "R7 inner body", rv, 32'h11);

        // R8: third nested call
        hwrite(9'h108, 32'h0);
        hwrite(9'h014, enc(8'h12, 0, 0, 0, 12'h01E));
        hwrite(9'h01E, enc(8'h05, 4'd8, 0, 0, 12'h0EE));
        hwrite(9'h01F, enc(8'h1F, 0, 0, 0, 0));
        run_prog();
        check(err == 1'b1 && done == 1'b1, "R8 overflow", {30'd0, done, err}, 32'h3);
        repeat (3) @(negedge clk);
        check(err == 1'b1, "R8 sticky", {31'd0, err}, 32'h1);
        stop_run();
        check(err == 1'b0, "R9 err cleared", {31'd0, err}, 32'h0);
        hread(9'h108, rv); check(rv == 32'h0, "R8 halted before target", rv, 32'h0);

        // R8: return with empty stack
        hwrite(9'h000, enc(8'h13, 0, 0, 0, 0));
        run_prog();
        check(err == 1'b1 && done == 1'b1, "R8 underflow", {30'd0, done, err}, 32'h3);
        stop_run();

        // R10: unassigned opcode is a no-op; back-to-back dependency (R5)
        hwrite(9'h109, 32'h1234_0000);
        hwrite(9'h000, enc(8'hEE, 4'd9, 0, 0, 12'h0FF));
        hwrite(9'h001, enc(8'h05, 4'd1, 0, 0, 12'h00F));
        hwrite(9'h002, enc(8'h03, 4'd2, 4'd1, 0, 12'h004));
        hwrite(9'h003, enc(8'h1F, 0, 0, 0, 0));
        run_prog();
        stop_run();
        hread(9'h109, rv); check(rv == 32'h1234_0000, "R10 nop no write", rv, 32'h1234_0000);
        hread(9'h102, rv); check(rv == 32'hF0, "R5 back-to-back", rv, 32'hF0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule